// File: doc/BRIEF.md
# Multi-mode programmable delay timer

The block drives a single active-low output from a trigger level and a clearing input. It has four modes. Three of them make the output the inverse of the trigger: delayed operate, delayed release and dual delay. They differ in whether the rising and falling trigger edges take effect on the next clock edge or only after a programmed delay. In the fourth mode, one-shot, a rising trigger edge produces a single timed low pulse.

The delay length comes from an 8-bit binary weight word W and a prescale factor S. The factor is picked by a 2-bit select. A tick-enable input pulses at twice the time-base rate, and only clock cycles with the tick high advance the timer. A non-one-shot delay lasts (2·W+1)·S ticks, which is S·(W+0.5) time-base periods. A one-shot pulse lasts 2·W·S ticks. The clearing input aborts any timing in progress and holds the output high. When the clear is released, the new output depends on the trigger level and the mode.

The controller has five states:
- HIGH: output high, idle.
- ARM_LO: output high, counting toward low.
- LOW: output low, idle.
- ARM_HI: output low, counting toward high.
- SHOT: one-shot pulse, output low.

The transitions are:
- HIGH to ARM_LO on a rise in delayed operate or dual delay.
- HIGH to LOW on a rise in delayed release.
- HIGH to SHOT on a rise in one-shot with W not zero.
- ARM_LO to LOW on expiry.
- ARM_LO to HIGH on a fall, which cancels the pending change.
- LOW to ARM_HI on a fall in delayed release or dual delay.
- LOW to HIGH on a fall in any other mode.
- ARM_HI to HIGH on expiry.
- ARM_HI to LOW on a rise, which cancels the pending change.
- SHOT to HIGH on expiry.
- Any state to HIGH while the clear is high.
- On release of the clear: to ARM_LO, LOW or HIGH by the release rule.

Top module: `dly_timer`

## Requirements
- R1: Mode encoding is 00 delayed operate, 01 delayed release, 10 dual delay and 11 one-shot. In modes 00, 01 and 10, once no delay is pending, `dly_n` equals the inverse of `trg_in`.
- R2: In delayed operate, a trigger rise drives `dly_n` low after the delay. A trigger fall drives it high on the clock edge that samples the fall.
- R3: In delayed release, a trigger rise drives `dly_n` low on the sampling edge. A trigger fall drives it high after the delay.
- R4: In dual delay, both trigger edges take effect only after the delay.
- R5: The delay is (2·W+1)·S ticks counted from the sampling edge. W is the sum of 2^i over the bits i of `wt` that are high.
- R6: `psc_sel` encodes S as follows: 00 gives 1, 01 gives 3000, 10 gives 3600, and 11 gives 1.
- R7: In one-shot mode, a trigger rise makes `dly_n` low on the sampling edge for exactly 2·W·S ticks. With W = 0 no pulse occurs.
- R8: During a one-shot pulse, further trigger edges are ignored. The pulse ends at its original time.
- R9: If the trigger returns to its earlier level before a pending delay expires, the pending change is cancelled and `dly_n` keeps its level.
- R10: While `tmr_clr` is high, `dly_n` is high in the same cycle, and any timing in progress is abandoned.
- R11: When `tmr_clr` falls while the trigger is low, `dly_n` stays high in every mode.
- R12: When `tmr_clr` falls while the trigger is high, the result depends on the mode. Delayed operate and dual delay start the delay and go low when it expires. Delayed release goes low on the next edge. One-shot stays high.
- R13: Only clock cycles with `tick_en` high advance the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| tick_en | input | 1 | Half-period time-base tick enable |
| tmr_clr | input | 1 | Timer clear, active high |
| trg_in | input | 1 | Trigger level, already synchronised |
| mode_sel | input | 2 | Operating mode |
| wt | input | 8 | Binary weight word W |
| psc_sel | input | 2 | Prescale factor select |
| dly_n | output | 1 | Active-low delay output |

## Verification
Each delay mode is driven with a trigger rise and a later fall, sampling one cycle before and on the expected expiry. This separates delayed from next-edge transitions and catches off-by-one spans. Weights with a single high bit and with mixed bits, together with all four prescale codes, tell a wrong bit weight or factor apart from a wrong half-unit offset. Short trigger glitches inside a pending delay and retriggers inside a pulse check cancellation and retrigger immunity. Clear pulses in each state, released with the trigger low and then high, plus an alternating tick pattern, cover the release rules and tick gating.

// File: rtl/dly_timer_pkg.sv
package dly_timer_pkg;

    typedef enum logic [1:0] {
        MD_OPER  = 2'b00,
        MD_RELS  = 2'b01,
        MD_BOTH  = 2'b10,
        MD_SHOT  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_HIGH   = 3'd0,
        ST_ARM_LO = 3'd1,
        ST_LOW    = 3'd2,
        ST_ARM_HI = 3'd3,
        ST_SHOT   = 3'd4
    } state_e;

endpackage

// File: rtl/dly_prescale.sv
module dly_prescale #(
    parameter int FACT_A = 3000,
    parameter int FACT_B = 3600,
    parameter int PC_W   = 12
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       start,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       unit
);

    logic [PC_W-1:0] fact_q;
    logic [PC_W-1:0] cnt_q;
    logic            last;

    function automatic logic [PC_W-1:0] pick(input logic [1:0] s);
        case (s)
            2'b01:   pick = PC_W'(FACT_A);
            2'b10:   pick = PC_W'(FACT_B);
            default: pick = PC_W'(1);
        endcase
    endfunction

    assign last = (cnt_q == fact_q - PC_W'(1));
    assign unit = run & tick & last;

    always_ff @(posedge clk) begin
        if (clr || start) begin
            fact_q <= pick(sel);
            cnt_q  <= '0;
        end else if (run && tick) begin
            cnt_q <= last ? '0 : cnt_q + PC_W'(1);
        end
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (clr)
        run |-> (cnt_q < fact_q)); // R6

endmodule

// File: rtl/dly_span.sv
module dly_span #(
    parameter int WB_W = 8,
    parameter int DC_W = 9
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            start,
    input  logic            shot,
    input  logic [WB_W-1:0] weight,
    input  logic            unit,
    output logic            done
);

    logic [DC_W-1:0] tgt_q;
    logic [DC_W-1:0] cnt_q;

    assign done = unit & (cnt_q == tgt_q - DC_W'(1));

    always_ff @(posedge clk) begin
        if (clr) begin
            tgt_q <= DC_W'(1);
            cnt_q <= '0;
        end else if (start) begin
            tgt_q <= shot ? {weight, 1'b0} : {weight, 1'b1};
            cnt_q <= '0;
        end else if (unit) begin
            cnt_q <= cnt_q + DC_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
        unit |-> (cnt_q < tgt_q)); // R5

endmodule

// File: rtl/dly_fsm.sv
module dly_fsm
    import dly_timer_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       trig,
    input  logic [1:0] mode,
    input  logic       wzero,
    input  logic       done,
    output logic       start,
    output logic       shot,
    output logic       run,
    output logic       high_lvl
);

    state_e state, nxt;
    logic   trig_q, clr_q;
    logic   rise, fall, release_ev;
    mode_e  md;

    assign md         = mode_e'(mode);
    assign rise       = trig & ~trig_q;
    assign fall       = ~trig & trig_q;
    assign release_ev = clr_q & ~clr;

    always_ff @(posedge clk) begin
        state  <= nxt;
        trig_q <= trig;
        clr_q  <= clr;
    end

    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = ST_HIGH;
        end else if (release_ev) begin
            nxt = ST_HIGH;
            if (trig) begin
                unique case (md)
                    MD_OPER, MD_BOTH: nxt = ST_ARM_LO;
                    MD_RELS:          nxt = ST_LOW;
                    default:          nxt = ST_HIGH;
                endcase
            end
        end else begin
            unique case (state)
                ST_HIGH: begin
                    if (rise) begin
                        unique case (md)
                            MD_OPER, MD_BOTH: nxt = ST_ARM_LO;
                            MD_RELS:          nxt = ST_LOW;
                            default:          nxt = wzero ? ST_HIGH : ST_SHOT;
                        endcase
                    end
                end
                ST_ARM_LO: begin
                    if (fall)      nxt = ST_HIGH;
                    else if (done) nxt = ST_LOW;
                end
                ST_LOW: begin
                    if (fall) begin
                        nxt = (md == MD_RELS || md == MD_BOTH) ? ST_ARM_HI : ST_HIGH;
                    end
                end
                ST_ARM_HI: begin
                    if (rise)      nxt = ST_LOW;
                    else if (done) nxt = ST_HIGH;
                end
                ST_SHOT: begin
                    if (done) nxt = ST_HIGH;
                end
                default: nxt = ST_HIGH;
            endcase
        end
    end

    always_comb begin
        high_lvl = (state == ST_HIGH) || (state == ST_ARM_LO);
        run      = (state == ST_ARM_LO) || (state == ST_ARM_HI) || (state == ST_SHOT);
        shot     = (nxt == ST_SHOT);
        start    = (nxt != state) &&
                   ((nxt == ST_ARM_LO) || (nxt == ST_ARM_HI) || (nxt == ST_SHOT));
    end

    AST_CLR_IDLE: assert property (@(posedge clk)
        clr |=> (state == ST_HIGH)); // R10

    AST_SHOT_HOLD: assert property (@(posedge clk) disable iff (clr)
        (state == ST_SHOT && !done) |=> (state == ST_SHOT)); // R8

    AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (clr)
        (start && shot) |-> !wzero); // R7

    AST_START_RUNS: assert property (@(posedge clk) disable iff (clr)
        start |=> run); // R5

endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
    parameter int WB_W   = 8,
    parameter int FACT_A = 3000,
    parameter int FACT_B = 3600
) (
    input  logic            clk,
    input  logic            tick_en,
    input  logic            tmr_clr,
    input  logic            trg_in,
    input  logic [1:0]      mode_sel,
    input  logic [WB_W-1:0] wt,
    input  logic [1:0]      psc_sel,
    output logic            dly_n
);

    localparam int FACT_MAX = (FACT_A > FACT_B) ? FACT_A : FACT_B;
    localparam int PC_W     = $clog2(FACT_MAX + 1);
    localparam int DC_W     = WB_W + 1;

    logic start, shot, run, high_lvl, unit, done;

    dly_fsm u_fsm (
        .clk      (clk),
        .clr      (tmr_clr),
        .trig     (trg_in),
        .mode     (mode_sel),
        .wzero    (wt == '0),
        .done     (done),
        .start    (start),
        .shot     (shot),
        .run      (run),
        .high_lvl (high_lvl)
    );

    dly_prescale #(.FACT_A(FACT_A), .FACT_B(FACT_B), .PC_W(PC_W)) u_psc (
        .clk   (clk),
        .clr   (tmr_clr),
        .start (start),
        .run   (run),
        .tick  (tick_en),
        .sel   (psc_sel),
        .unit  (unit)
    );

    dly_span #(.WB_W(WB_W), .DC_W(DC_W)) u_span (
        .clk    (clk),
        .clr    (tmr_clr),
        .start  (start),
        .shot   (shot),
        .weight (wt),
        .unit   (unit),
        .done   (done)
    );

    assign dly_n = tmr_clr ? 1'b1 : high_lvl;

endmodule

// File: tb/sim_dly_timer.sv
module sim_dly_timer;

    logic       clk = 1'b0;
    logic       tick_en = 1'b1;
    logic       tmr_clr = 1'b1;
    logic       trg_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [7:0] wt = 8'd0;
    logic [1:0] psc_sel = 2'b00;
    logic       dly_n;

    int  cyc = 0;
    int  checks = 0;
    int  failures = 0;
    bit  alt_tick = 1'b0;
    bit  ended = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];

    dly_timer u0 (
        .clk      (clk),
        .tick_en  (tick_en),
        .tmr_clr  (tmr_clr),
        .trg_in   (trg_in),
        .mode_sel (mode_sel),
        .wt       (wt),
        .psc_sel  (psc_sel),
        .dly_n    (dly_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) tick_en <= alt_tick ? (cyc % 2 == 1) : 1'b1;

    // monitor: pops and compares expected items away from the active edge
    always @(negedge clk) begin
        #2;
        while (sb.size() != 0 && sb[0].at <= cyc) begin
            checks++;
            if (sb[0].at < cyc) begin
                failures++;
                $display("FAIL %s missed cycle %0d actual=- expected=%b", sb[0].tag, sb[0].at, sb[0].val);
            end else if (dly_n !== sb[0].val) begin
                failures++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", sb[0].tag, cyc, dly_n, sb[0].val);
            end
            void'(sb.pop_front());
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_at(input int at, input logic v, input string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expo(input int off, input logic v, input string tag);
        exp_at(cyc + off, v, tag);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        step(1);
    endtask

    task automatic setup(input logic [1:0] m, input logic [7:0] w, input logic [1:0] p);
        tmr_clr = 1'b1; trg_in = 1'b0;
        mode_sel = m; wt = w; psc_sel = p;
        step(2);
        tmr_clr = 1'b0;
        step(2);
    endtask

    initial begin
        int c0;
        step(3);
        expo(0, 1'b1, "R10 reset state");
        drain();

        // R2 delayed operate, W=3 -> 7 ticks
        setup(2'b00, 8'd3, 2'b00);
        trg_in = 1'b1;
        expo(1, 1'b1, "R2 no early low"); expo(7, 1'b1, "R2 before expiry"); expo(8, 1'b0, "R2 expiry");
        drain(); step(3);
        expo(0, 1'b0, "R1 steady inverse");
        drain();
        trg_in = 1'b0;
        expo(0, 1'b0, "R2 before edge"); expo(1, 1'b1, "R2 fall next edge");
        drain();

        // R3 delayed release, W=2 -> 5 ticks
        setup(2'b01, 8'd2, 2'b00);
        trg_in = 1'b1;
        expo(0, 1'b1, "R3 before edge"); expo(1, 1'b0, "R3 rise next edge");
        drain(); step(2);
        trg_in = 1'b0;
        expo(5, 1'b0, "R3 before expiry"); expo(6, 1'b1, "R3 expiry");
        drain();

        // R4 dual delay, W=1 -> 3 ticks
        setup(2'b10, 8'd1, 2'b00);
        trg_in = 1'b1;
        expo(3, 1'b1, "R4 rise held"); expo(4, 1'b0, "R4 rise expiry");
        drain(); step(2);
        trg_in = 1'b0;
        expo(3, 1'b0, "R4 fall held"); expo(4, 1'b1, "R4 fall expiry");
        drain(); step(2);
        expo(0, 1'b1, "R1 steady inverse low trigger");
        drain();

        // R5 bit weights
        setup(2'b00, 8'h80, 2'b00);
        trg_in = 1'b1;
        expo(257, 1'b1, "R5 W=128 before"); expo(258, 1'b0, "R5 W=128 expiry");
        drain();
        setup(2'b00, 8'h05, 2'b00);
        trg_in = 1'b1;
        expo(11, 1'b1, "R5 W=5 before"); expo(12, 1'b0, "R5 W=5 expiry");
        drain();

        // R6 prescale codes
        setup(2'b00, 8'd0, 2'b01);
        trg_in = 1'b1;
        expo(3000, 1'b1, "R6 S=3000 before"); expo(3001, 1'b0, "R6 S=3000 expiry");
        drain();
        setup(2'b01, 8'd1, 2'b10);
        trg_in = 1'b1; step(3);
        trg_in = 1'b0;
        expo(10800, 1'b0, "R6 S=3600 before"); expo(10801, 1'b1, "R6 S=3600 expiry");
        drain();
        setup(2'b00, 8'd2, 2'b11);
        trg_in = 1'b1;
        expo(5, 1'b1, "R6 code 11 before"); expo(6, 1'b0, "R6 code 11 expiry");
        drain();

        // R7 one-shot
        setup(2'b11, 8'd2, 2'b00);
        trg_in = 1'b1;
        expo(1, 1'b0, "R7 pulse start"); expo(4, 1'b0, "R7 pulse hold"); expo(5, 1'b1, "R7 pulse end");
        drain();
        setup(2'b11, 8'd1, 2'b10);
        trg_in = 1'b1;
        expo(7200, 1'b0, "R7 scaled before"); expo(7201, 1'b1, "R7 scaled end");
        drain();
        setup(2'b11, 8'd0, 2'b00);
        trg_in = 1'b1;
        expo(1, 1'b1, "R7 W=0 no pulse"); expo(5, 1'b1, "R7 W=0 still high");
        drain();

        // R8 retrigger ignored, W=3 -> 6 ticks
        setup(2'b11, 8'd3, 2'b00);
        trg_in = 1'b1; c0 = cyc;
        step(2); trg_in = 1'b0;
        step(2); trg_in = 1'b1;
        exp_at(c0 + 6, 1'b0, "R8 retrigger before end");
        exp_at(c0 + 7, 1'b1, "R8 original end");
        exp_at(c0 + 10, 1'b1, "R8 no second pulse");
        drain();

        // R9 cancellation
        setup(2'b00, 8'd3, 2'b00);
        trg_in = 1'b1; step(3); trg_in = 1'b0;
        expo(7, 1'b1, "R9 operate cancelled"); expo(9, 1'b1, "R9 operate stays high");
        drain();
        setup(2'b01, 8'd3, 2'b00);
        trg_in = 1'b1; step(3); trg_in = 1'b0; step(3); trg_in = 1'b1;
        expo(7, 1'b0, "R9 release cancelled"); expo(9, 1'b0, "R9 release stays low");
        drain();

        // R10/R11 clear in LOW, release with trigger low
        setup(2'b00, 8'd0, 2'b00);
        trg_in = 1'b1; step(4);
        tmr_clr = 1'b1;
        expo(0, 1'b1, "R10 forced high same cycle");
        drain(); trg_in = 1'b0; step(2);
        tmr_clr = 1'b0;
        expo(1, 1'b1, "R11 release low trigger"); expo(10, 1'b1, "R11 stays high");
        drain();
        // R10 abort pending rise in dual delay
        setup(2'b10, 8'd3, 2'b00);
        trg_in = 1'b1; step(3);
        tmr_clr = 1'b1; step(2); trg_in = 1'b0; step(1);
        tmr_clr = 1'b0;
        expo(12, 1'b1, "R10 timing abandoned");
        drain();

        // R12 release with trigger high
        setup(2'b00, 8'd1, 2'b00);
        tmr_clr = 1'b1; trg_in = 1'b1; step(3); tmr_clr = 1'b0;
        expo(1, 1'b1, "R12 operate start"); expo(3, 1'b1, "R12 operate before"); expo(4, 1'b0, "R12 operate expiry");
        drain();
        setup(2'b10, 8'd1, 2'b00);
        tmr_clr = 1'b1; trg_in = 1'b1; step(3); tmr_clr = 1'b0;
        expo(3, 1'b1, "R12 dual before"); expo(4, 1'b0, "R12 dual expiry");
        drain();
        setup(2'b01, 8'd1, 2'b00);
        tmr_clr = 1'b1; trg_in = 1'b1; step(3); tmr_clr = 1'b0;
        expo(0, 1'b1, "R12 release before edge"); expo(1, 1'b0, "R12 release next edge");
        drain();
        setup(2'b11, 8'd2, 2'b00);
        tmr_clr = 1'b1; trg_in = 1'b1; step(3); tmr_clr = 1'b0;
        expo(1, 1'b1, "R12 one-shot stays high"); expo(6, 1'b1, "R12 one-shot no pulse");
        drain();

        // R13 tick gating: ticks on even edges only, W=1 -> 3 ticks
        setup(2'b00, 8'd1, 2'b00);
        alt_tick = 1'b1;
        step(1);
        while (cyc % 2 == 0) step(1);
        trg_in = 1'b1;
        expo(6, 1'b1, "R13 gated before"); expo(7, 1'b0, "R13 gated expiry");
        drain();
        alt_tick = 1'b0;

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule